// File: doc/BRIEF.md
# LPI Pending-Bit Read-Modify-Write Engine

This block sets or clears the pending state of one message-signalled interrupt at a time. The pending states are kept as a bitmap in external memory, one bit per interrupt number. A request comes either from a register write (a set or a clear command carrying an interrupt number) or from the CPU acknowledge port, which clears the pending bit of the interrupt being taken. These interrupts have no active state.

For each accepted request the engine forms the byte address from a programmable table base and reads that byte through a simple request/response memory port. It then tests the addressed bit. If the bit must change, the engine writes the modified byte back and pulses an update output for one cycle. If the bit already has the wanted value, the request ends with no write. A global enable bit and the table geometry gate every request. Only one read-modify-write runs at a time. A busy output tells requesters to hold off until the current operation is over.

Top module: `lpi_pend_engine`

## Requirements
- R1: After reset the engine is idle (busy 0), update 0, no memory request, and the control, properties and table-base registers all read 0.
- R2: The byte touched for interrupt number N is at address base + (N >> 3), and its bit is N mod 8. The other seven bits are written back unchanged.
- R3: The enable bit is bit 0 of the control register (select 0). While it is 0, every set, clear and acknowledge request is dropped: no memory access and no update pulse.
- R4: A request is dropped if N is below 8192 or above (1 << (W+1)) - 1. W is the width field in bits [4:0] of the properties register (select 1). A written value above 15 is stored and read back as 15.
- R5: A set command (register select 3, number in data[31:0]) on a non-pending number writes the byte with that bit at 1 and pulses update.
- R6: A clear command (register select 4, number in data[31:0]) on a pending number writes the byte with that bit at 0 and pulses update.
- R7: A set on a pending number, or a clear on a non-pending number, performs the read but no write and no update pulse.
- R8: An acknowledge (ackValid with ackId) acts as a clear of that number. If an acknowledge and a set or clear command arrive in the same cycle, the acknowledge is taken and the command is dropped.
- R9: Busy is high from the cycle after a request is accepted until its operation ends. Requests that arrive while busy is high are dropped. No memory request is made while busy is low.
- R10: Update is high for exactly one cycle: the cycle after the write-back is accepted by memory.
- R11: The table-base register (select 2) keeps only address bits [51:16]. All other written bits read back as 0.
- R12: A memory request holds its valid, direction, address and write data stable until memReqReady accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 3 | Write select: 0 control, 1 properties, 2 table base, 3 set, 4 clear |
| regWrData | input | 64 | Register write data |
| regRdSel | input | 3 | Read select (0 control, 1 properties, 2 table base) |
| regRdData | output | 64 | Read data for regRdSel |
| ackValid | input | 1 | CPU acknowledge of an interrupt |
| ackId | input | 32 | Acknowledged interrupt number |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts request |
| memReqWrite | output | 1 | 1 write, 0 read |
| memReqAddr | output | 52 | Byte address |
| memReqWdata | output | 8 | Write byte |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 8 | Read byte |
| busy | output | 1 | Operation in progress |
| updatePulse | output | 1 | One-cycle notice of a changed pending bit |

## Verification
The bench builds the engine with its default parameters: a 52-bit address, table base bits from 16 upward, a width field capped at 15, and the first number at 8192. With these, the bench can move the width field between 12, 13 and 15. That makes it possible to drop every number, or to place the top limit inside a small 8 KiB memory model. Random ready stalls stretch each operation, so commands that land while busy is high and requests held across stalls are reached.

// File: rtl/lpi_pend_pkg.sv
package lpi_pend_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_PROPS = 3'd1,
    SEL_BASE  = 3'd2,
    SEL_SET   = 3'd3,
    SEL_CLR   = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RDREQ  = 2'd1,
    ST_RDWAIT = 2'd2,
    ST_WRREQ  = 2'd3
  } rmw_state_e;

  typedef struct packed {
    logic capReq;
    logic capByte;
  } ctrl_strb_t;

endpackage

// File: rtl/lpi_pend_dp.sv
module lpi_pend_dp
  import lpi_pend_pkg::*;
#(
  parameter int AddrW     = 52,
  parameter int BaseLsb   = 16,
  parameter int DataW     = 64,
  parameter int IdW       = 32,
  parameter int MaxIdBits = 15,
  parameter int FirstId   = 8192
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regWrSel,
  input  logic [DataW-1:0] regWrData,
  input  logic [2:0]       regRdSel,
  output logic [DataW-1:0] regRdData,
  input  logic             ackValid,
  input  logic [IdW-1:0]   ackId,
  input  ctrl_strb_t       strb,
  input  logic             memReqValid,
  input  logic             memReqWrite,
  input  logic [7:0]       memRespData,
  output logic             startReq,
  output logic             reqOk,
  output logic             needWrite,
  output logic [AddrW-1:0] memReqAddr,
  output logic [7:0]       memReqWdata
);

  localparam int BaseW = AddrW - BaseLsb;

  logic             enableQ;
  logic [4:0]       idBitsQ;
  logic [BaseW-1:0] pendBaseQ;
  logic [IdW-1:0]   reqIdQ;
  logic             reqSetQ;
  logic [7:0]       wrByteQ;

  logic [IdW-1:0]   inId;
  logic             inSet;
  logic             cmdWr;
  logic [IdW:0]     largestId;
  logic [7:0]       bitMask;
  logic             bitVal;

  assign cmdWr    = regWrEn && (regWrSel == SEL_SET || regWrSel == SEL_CLR);
  assign startReq = ackValid || cmdWr;
  assign inId     = ackValid ? ackId : regWrData[IdW-1:0];
  assign inSet    = !ackValid && (regWrSel == SEL_SET);

  assign largestId = ((IdW+1)'(1) << (6'(idBitsQ) + 6'd1)) - (IdW+1)'(1);

  assign reqOk = enableQ && (inId >= IdW'(FirstId)) && ({1'b0, inId} <= largestId);

  assign bitMask   = 8'(1) << reqIdQ[2:0];
  assign bitVal    = |(memRespData & bitMask);
  assign needWrite = reqSetQ ? !bitVal : bitVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= 1'b0;
      idBitsQ   <= '0;
      pendBaseQ <= '0;
    end else if (regWrEn) begin
      case (regWrSel)
        SEL_CTRL:  enableQ <= regWrData[0];
        SEL_PROPS: idBitsQ <= (regWrData[4:0] > 5'(MaxIdBits)) ? 5'(MaxIdBits) : regWrData[4:0];
        SEL_BASE:  pendBaseQ <= regWrData[AddrW-1:BaseLsb];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqIdQ  <= '0;
      reqSetQ <= 1'b0;
      wrByteQ <= '0;
    end else begin
      if (strb.capReq) begin
        reqIdQ  <= inId;
        reqSetQ <= inSet;
      end
      if (strb.capByte) begin
        wrByteQ <= reqSetQ ? (memRespData | bitMask) : (memRespData & ~bitMask);
      end
    end
  end

  assign memReqAddr  = {pendBaseQ, BaseLsb'(0)} + AddrW'(reqIdQ >> 3);
  assign memReqWdata = wrByteQ;

  always_comb begin
    regRdData = '0;
    case (regRdSel)
      SEL_CTRL:  regRdData = DataW'(enableQ);
      SEL_PROPS: regRdData = DataW'(idBitsQ);
      SEL_BASE:  regRdData = DataW'({pendBaseQ, BaseLsb'(0)});
      default:   regRdData = '0;
    endcase
  end

  AST_WDATA_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> (memReqWdata[reqIdQ[2:0]] == reqSetQ)); // R5
  AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !enableQ) |-> !strb.capReq); // R3

endmodule

// File: rtl/lpi_pend_ctrl.sv
module lpi_pend_ctrl
  import lpi_pend_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       reqOk,
  input  logic       needWrite,
  input  logic       memReqReady,
  input  logic       memRespValid,
  output ctrl_strb_t strb,
  output logic       busy,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       updatePulse
);

  rmw_state_e stateQ, stateD;
  logic       updD;

  always_comb begin
    stateD       = stateQ;
    strb.capReq  = 1'b0;
    strb.capByte = 1'b0;
    updD         = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (startReq && reqOk) begin
          strb.capReq = 1'b1;
          stateD      = ST_RDREQ;
        end
      end
      ST_RDREQ: begin
        if (memReqReady) stateD = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        if (memRespValid) begin
          strb.capByte = 1'b1;
          stateD       = needWrite ? ST_WRREQ : ST_IDLE;
        end
      end
      ST_WRREQ: begin
        if (memReqReady) begin
          updD   = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      updatePulse <= 1'b0;
    end else begin
      stateQ      <= stateD;
      updatePulse <= updD;
    end
  end

  assign busy        = (stateQ != ST_IDLE);
  assign memReqValid = (stateQ == ST_RDREQ) || (stateQ == ST_WRREQ);
  assign memReqWrite = (stateQ == ST_WRREQ);

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid); // R9
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |=> !updatePulse); // R10
  AST_UPD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && memReqReady) |=> updatePulse); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqWrite))); // R12

endmodule

// File: rtl/lpi_pend_engine.sv
module lpi_pend_engine
  import lpi_pend_pkg::*;
#(
  parameter int AddrW     = 52,
  parameter int BaseLsb   = 16,
  parameter int DataW     = 64,
  parameter int IdW       = 32,
  parameter int MaxIdBits = 15,
  parameter int FirstId   = 8192
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regWrSel,
  input  logic [DataW-1:0] regWrData,
  input  logic [2:0]       regRdSel,
  output logic [DataW-1:0] regRdData,
  input  logic             ackValid,
  input  logic [IdW-1:0]   ackId,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic             memReqWrite,
  output logic [AddrW-1:0] memReqAddr,
  output logic [7:0]       memReqWdata,
  input  logic             memRespValid,
  input  logic [7:0]       memRespData,
  output logic             busy,
  output logic             updatePulse
);

  ctrl_strb_t strb;
  logic       startReq;
  logic       reqOk;
  logic       needWrite;

  lpi_pend_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .reqOk        (reqOk),
    .needWrite    (needWrite),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .strb         (strb),
    .busy         (busy),
    .memReqValid  (memReqValid),
    .memReqWrite  (memReqWrite),
    .updatePulse  (updatePulse)
  );

  lpi_pend_dp #(
    .AddrW(AddrW), .BaseLsb(BaseLsb), .DataW(DataW),
    .IdW(IdW), .MaxIdBits(MaxIdBits), .FirstId(FirstId)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrSel    (regWrSel),
    .regWrData   (regWrData),
    .regRdSel    (regRdSel),
    .regRdData   (regRdData),
    .ackValid    (ackValid),
    .ackId       (ackId),
    .strb        (strb),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .memRespData (memRespData),
    .startReq    (startReq),
    .reqOk       (reqOk),
    .needWrite   (needWrite),
    .memReqAddr  (memReqAddr),
    .memReqWdata (memReqWdata)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> ($stable(memReqAddr) && $stable(memReqWdata))); // R12

endmodule

// File: tb/lpi_pend_engine_tb_top.sv
`timescale 1ns/1ps
module lpi_pend_engine_tb_top;

  localparam int    MemBytes = 8192;
  localparam logic [63:0] BaseVal = 64'h0000_0123_4567_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrSel = '0;
  logic [63:0] regWrData = '0;
  logic [2:0]  regRdSel = '0;
  logic [63:0] regRdData;
  logic        ackValid = 1'b0;
  logic [31:0] ackId = '0;
  logic        memReqValid, memReqWrite;
  logic        memReqReady = 1'b0;
  logic [51:0] memReqAddr;
  logic [7:0]  memReqWdata;
  logic        memRespValid = 1'b0;
  logic [7:0]  memRespData = '0;
  logic        busy, updatePulse;

  logic [7:0] mem    [MemBytes];
  logic [7:0] refMem [MemBytes];
  int rdCount = 0, wrCount = 0, updCount = 0, badAddr = 0;
  int checks = 0, errors = 0;
  int refEn = 0, refIdBits = 0;

  always #2 clk = ~clk;

  lpi_pend_engine dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdData(regRdData),
    .ackValid(ackValid), .ackId(ackId), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memRespValid(memRespValid), .memRespData(memRespData),
    .busy(busy), .updatePulse(updatePulse)
  );

  always @(posedge clk) begin
    memRespValid <= 1'b0;
    if (memReqValid && memReqReady) begin
      longint idx;
      idx = longint'({12'b0, memReqAddr}) - longint'(BaseVal);
      if (idx < 0 || idx >= MemBytes) badAddr++;
      else if (memReqWrite) begin
        mem[idx] <= memReqWdata;
        wrCount++;
      end else begin
        memRespValid <= 1'b1;
        memRespData  <= mem[idx];
        rdCount++;
      end
    end
    memReqReady <= ($urandom_range(0, 3) != 0);
  end

  always @(negedge clk) if (updatePulse) updCount++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [63:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic bit inRange(input longint id);
    longint top;
    top = (longint'(1) << (refIdBits + 1)) - 1;
    return refEn != 0 && id >= 8192 && id <= top;
  endfunction

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
    @(negedge clk); @(negedge clk); #1;
  endtask

  // op: 0 set, 1 clear, 2 ack
  task automatic doReq(input int op, input int id, input string req);
    int r0, w0, u0, expR, expW;
    bit ok, pend, chg;
    r0 = rdCount; w0 = wrCount; u0 = updCount;
    ok = inRange(id);
    pend = ok ? refMem[id >> 3][id % 8] : 1'b0;
    chg = ok && ((op == 0) ? !pend : pend);
    expR = ok ? 1 : 0;
    expW = chg ? 1 : 0;
    if (chg) refMem[id >> 3][id % 8] = (op == 0);
    @(negedge clk);
    if (op == 2) begin ackValid = 1'b1; ackId = id; end
    else begin regWrEn = 1'b1; regWrSel = (op == 0) ? 3'd3 : 3'd4; regWrData = 64'(id); end
    @(negedge clk);
    ackValid = 1'b0; regWrEn = 1'b0;
    waitIdle();
    check(rdCount - r0 == expR && wrCount - w0 == expW && updCount - u0 == expW,
          req, longint'((rdCount - r0) * 100 + (wrCount - w0) * 10 + (updCount - u0)),
          longint'(expR * 100 + expW * 10 + expW));
    if (ok) check(mem[id >> 3] == refMem[id >> 3], {req, " R2 byte"},
                  longint'(mem[id >> 3]), longint'(refMem[id >> 3]));
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < MemBytes; i++) begin
      mem[i] = 8'($urandom);
      refMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(!busy && !updatePulse && !memReqValid, "R1 idle", longint'({busy, updatePulse, memReqValid}), 0);
    for (int s = 0; s < 3; s++) begin
      regRdSel = 3'(s); #1;
      check(regRdData == 0, "R1 reg", longint'(regRdData), 0);
    end
    // R11 base readback mask
    regWrite(3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    regRdSel = 3'd2; #1;
    check(regRdData == 64'h000F_FFFF_FFFF_0000, "R11 base", longint'(regRdData), longint'(64'h000F_FFFF_FFFF_0000));
    regWrite(3'd2, BaseVal | 64'hABCD);
    #1;
    check(regRdData == BaseVal, "R11 base2", longint'(regRdData), longint'(BaseVal));
    // R4 clamp
    regWrite(3'd1, 64'h1F);
    regRdSel = 3'd1; #1;
    check(regRdData == 64'hF, "R4 clamp", longint'(regRdData), 15);
    refIdBits = 15;
    // R3 disabled: nothing happens
    doReq(0, 9000, "R3 disabled set");
    doReq(2, 9001, "R3 disabled ack");
    regWrite(3'd0, 64'h1);
    refEn = 1;
    regRdSel = 3'd0; #1;
    check(regRdData == 64'h1, "R3 enable readback", longint'(regRdData), 1);
    // R5 / R6 / R7 directed
    doReq(1, 8200, "R6 prep clear");
    doReq(0, 8200, "R5 set");
    doReq(0, 8200, "R7 set again");
    doReq(1, 8200, "R6 clear");
    doReq(1, 8200, "R7 clear again");
    doReq(0, 8192, "R4 first id");
    doReq(0, 8191, "R4 below first");
    doReq(0, 65535, "R4 top id");
    // R4 narrower width: 12 drops everything, 13 tops at 16383
    regWrite(3'd1, 64'd12); refIdBits = 12;
    doReq(0, 8300, "R4 width12");
    regWrite(3'd1, 64'd13); refIdBits = 13;
    doReq(0, 16383, "R4 top13");
    doReq(0, 16384, "R4 above13");
    // R8 ack clears; ack beats a simultaneous command
    doReq(0, 9100, "R8 prep");
    doReq(2, 9100, "R8 ack clear");
    begin
      int w0 = wrCount;
      if (!refMem[9104 >> 3][9104 % 8]) doReq(0, 9104, "R8 prep2");
      w0 = wrCount;
      @(negedge clk);
      ackValid = 1'b1; ackId = 9104;
      regWrEn = 1'b1; regWrSel = 3'd3; regWrData = 64'd9300;
      @(negedge clk);
      ackValid = 1'b0; regWrEn = 1'b0;
      waitIdle();
      refMem[9104 >> 3][9104 % 8] = 1'b0;
      check(mem[9104 >> 3] == refMem[9104 >> 3] && mem[9300 >> 3] == refMem[9300 >> 3],
            "R8 priority", longint'(mem[9300 >> 3]), longint'(refMem[9300 >> 3]));
      check(wrCount - w0 == 1, "R8 one write", longint'(wrCount - w0), 1);
    end
    // R9 command while busy dropped
    begin
      int tid = 9500;
      if (refMem[tid >> 3][tid % 8]) doReq(1, tid, "R9 prep");
      if (refMem[9600 >> 3][9600 % 8]) doReq(1, 9600, "R9 prep2");
      @(negedge clk);
      regWrEn = 1'b1; regWrSel = 3'd3; regWrData = 64'(tid);
      @(negedge clk);
      regWrData = 64'd9600;
      #1;
      check(busy == 1'b1, "R9 busy", longint'(busy), 1);
      @(negedge clk);
      regWrEn = 1'b0;
      waitIdle();
      refMem[tid >> 3][tid % 8] = 1'b1;
      check(mem[9600 >> 3][9600 % 8] == 1'b0, "R9 dropped", longint'(mem[9600 >> 3][9600 % 8]), 0);
      check(mem[tid >> 3] == refMem[tid >> 3], "R9 first done", longint'(mem[tid >> 3]), longint'(refMem[tid >> 3]));
    end
    // R10 pulse width: upd count equals write count over random run
    regWrite(3'd1, 64'd15); refIdBits = 15;
    begin
      int w0 = wrCount, u0 = updCount;
      for (int i = 0; i < 300; i++) begin
        int op = $urandom_range(0, 2);
        int id = $urandom_range(8180, 8500);
        if (i % 37 == 0) begin
          regWrite(3'd0, 64'(i % 2)); refEn = i % 2;
        end
        doReq(op, id, "R5 R6 R7 R8 random");
      end
      check(updCount - u0 == wrCount - w0, "R10 pulse count",
            longint'(updCount - u0), longint'(wrCount - w0));
    end
    check(badAddr == 0, "R2 address range", longint'(badAddr), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule